// File: doc/BRIEF.md
# Programmable Input Glitch Filter

This block cleans one already-synchronized timer input before it reaches edge detection. It takes samples of the raw level at a chosen rate. A level change is passed to the filtered output only after a set number of back-to-back samples all disagree with the current output level. Any sample that agrees with the output cancels the change that was building up.

A 4-bit filter code chooses three things together: the sampling source (kernel clock enable or dead-time clock enable), a divider of 2 to 32 applied to the dead-time enable, and the count of agreeing samples, from 2 to 8. Code 0 turns the filter off. In that mode the output copies the input on every dead-time enable.

A change of code clears the sample counter and the rate divider. The output keeps its present level.

Top module: `tgf_top`

## Requirements
- R1: After reset the filtered output `sig_out` is 0.
- R2: With code 0 the filter is bypassed. On every cycle with `dts_ce` high, `sig_out` takes the value `sig_in` had in that cycle, one clock later. `kern_ce` has no effect in this mode.
- R3: Codes 1, 2 and 3 take a sample on every cycle with `kern_ce` high and need 2, 4 and 8 agreeing samples respectively. `dts_ce` has no effect for these codes.
- R4: Codes 4 and 5 sample on every 2nd `dts_ce` pulse. Codes 6 and 7 sample on every 4th pulse, and codes 8 and 9 on every 8th pulse. The even code of each pair needs 6 samples and the odd code needs 8.
- R5: Codes 10, 11 and 12 sample on every 16th `dts_ce` pulse and need 5, 6 and 8 samples. Codes 13, 14 and 15 sample on every 32nd pulse and need 5, 6 and 8 samples.
- R6: With filtering on, `sig_out` inverts one clock after the N-th consecutive sample that differs from it. A sample equal to `sig_out` sets the run count back to zero. The count also restarts after each inversion.
- R7: In a cycle without a sample (the selected enable is low, or the divider is not at its last step), `sig_out` does not change in the next cycle.
- R8: In the cycle where `fcode` differs from its value in the previous cycle, no sample is taken. The run count and the divider clear, and `sig_out` keeps its level.
- R9: The divider is free-running on `dts_ce`. After a code change, the first divided sample falls on the D-th `dts_ce` pulse, where D is the division of the new code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kern_ce | input | 1 | Kernel-rate sample enable |
| dts_ce | input | 1 | Dead-time-rate enable, the input to the divider |
| fcode | input | 4 | Filter code: sample rate and required sample count |
| sig_in | input | 1 | Synchronized raw input level |
| sig_out | output | 1 | Filtered level |

## Verification
The bench builds the block with its default divider width of 5 bits. This is the smallest width that reaches the divide-by-32 codes, so the longest validation windows (8 samples × 32 pulses) are exercised end to end. Directed runs place glitches one sample shorter than N for each code family, change the code in the middle of a run, and gate both enables. A long random phase with slowly changing inputs and occasional code changes then compares every cycle against a model of the rate and count tables.

// File: rtl/tgf_pkg.sv
package tgf_pkg;
  localparam int FC_W  = 4;  // filter code width
  localparam int SH_W  = 3;  // divider shift width (0..5)
  localparam int LEN_W = 4;  // required sample count width (1..8)

  // log2 of the dead-time divider picked by a code
  function automatic logic [SH_W-1:0] fc_shift(input logic [FC_W-1:0] c);
    logic [SH_W-1:0] s;
    unique case (c)
      4'd4, 4'd5:          s = 3'd1;
      4'd6, 4'd7:          s = 3'd2;
      4'd8, 4'd9:          s = 3'd3;
      4'd10, 4'd11, 4'd12: s = 3'd4;
      4'd13, 4'd14, 4'd15: s = 3'd5;
      default:             s = 3'd0;
    endcase
    return s;
  endfunction

  // number of agreeing samples needed to flip the output
  function automatic logic [LEN_W-1:0] fc_len(input logic [FC_W-1:0] c);
    logic [LEN_W-1:0] n;
    unique case (c)
      4'd0:                       n = 4'd1;
      4'd1:                       n = 4'd2;
      4'd2:                       n = 4'd4;
      4'd10, 4'd13:               n = 4'd5;
      4'd4, 4'd6, 4'd8, 4'd11, 4'd14: n = 4'd6;
      default:                    n = 4'd8;
    endcase
    return n;
  endfunction

  function automatic logic fc_kernel(input logic [FC_W-1:0] c);
    return (c == 4'd1) || (c == 4'd2) || (c == 4'd3);
  endfunction

  function automatic logic fc_bypass(input logic [FC_W-1:0] c);
    return c == '0;
  endfunction
endpackage

// File: rtl/tgf_sampler.sv
module tgf_sampler
  import tgf_pkg::*;
#(
  parameter int DIV_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            kern_ce,
  input  logic            dts_ce,
  input  logic [FC_W-1:0] code,
  output logic            tick
);
  localparam logic [DIV_W-1:0] ALL_ONES = {DIV_W{1'b1}};

  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_last;
  logic             div_wrap;
  logic [SH_W-1:0]  sh;

  assign sh       = fc_shift(code);
  assign div_last = ALL_ONES >> (DIV_W - int'(sh));
  assign div_wrap = (div_cnt == div_last);
  assign tick     = fc_kernel(code) ? kern_ce : (dts_ce & div_wrap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_cnt <= '0;
    else if (clr)    div_cnt <= '0;
    else if (dts_ce) div_cnt <= div_wrap ? '0 : div_cnt + 1'b1;
  end

  // R9: the divider never passes its last step
  p_div_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    div_cnt <= div_last || $changed(code));
  // R8: a clear request empties the divider
  p_div_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> div_cnt == '0);
endmodule

// File: rtl/tgf_event_cnt.sv
module tgf_event_cnt
  import tgf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic             bypass,
  input  logic [LEN_W-1:0] n_len,
  input  logic             sig_in,
  output logic             sig_out
);
  logic [LEN_W-1:0] run_cnt;
  logic             differs;
  logic             full;

  assign differs = (sig_in != sig_out);
  assign full    = (run_cnt == n_len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      sig_out <= 1'b0;
    end else if (clr) begin
      run_cnt <= '0;
    end else if (tick) begin
      if (bypass) begin
        sig_out <= sig_in;
        run_cnt <= '0;
      end else if (!differs) begin
        run_cnt <= '0;
      end else if (full) begin
        sig_out <= ~sig_out;
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  // R7: without a sample the level holds
  p_hold_no_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sig_out));
  // R2: bypass copies the sampled level
  p_bypass_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && bypass && !clr) |=> sig_out == $past(sig_in));
  // R6: the N-th differing sample flips the output
  p_flip_at_n_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !bypass && !clr && differs && full) |=> sig_out != $past(sig_out));
  // R6: an agreeing sample restarts the run
  p_agree_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !bypass && !clr && !differs) |=> run_cnt == '0);
endmodule

// File: rtl/tgf_top.sv
module tgf_top
  import tgf_pkg::*;
#(
  parameter int DIV_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            kern_ce,
  input  logic            dts_ce,
  input  logic [FC_W-1:0] fcode,
  input  logic            sig_in,
  output logic            sig_out
);
  logic [FC_W-1:0] code_q;
  logic            code_chg;
  logic            tick;

  assign code_chg = (fcode != code_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= fcode;
  end

  tgf_sampler #(.DIV_W(DIV_W)) u_smp (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (code_chg),
    .kern_ce(kern_ce),
    .dts_ce (dts_ce),
    .code   (fcode),
    .tick   (tick)
  );

  tgf_event_cnt u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (code_chg),
    .tick   (tick),
    .bypass (fc_bypass(fcode)),
    .n_len  (fc_len(fcode)),
    .sig_in (sig_in),
    .sig_out(sig_out)
  );

  // R8: a code change never moves the output
  p_code_chg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    code_chg |=> $stable(sig_out));
endmodule

// File: tb/sim_tgf_top.sv
module sim_tgf_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       kern_ce = 1'b0;
  logic       dts_ce = 1'b0;
  logic [3:0] fcode = 4'd0;
  logic       sig_in = 1'b0;
  logic       sig_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tgf_top u0 (
    .clk(clk), .rst_n(rst_n), .kern_ce(kern_ce), .dts_ce(dts_ce),
    .fcode(fcode), .sig_in(sig_in), .sig_out(sig_out)
  );

  typedef struct { logic v; string tag; } exp_t;
  exp_t q[$];

  // reference tables, written from the requirements
  int nt[16] = '{1, 2, 4, 8, 6, 8, 6, 8, 6, 8, 5, 6, 8, 5, 6, 8};
  int dv[16] = '{1, 1, 1, 1, 2, 2, 4, 4, 8, 8, 16, 16, 16, 32, 32, 32};

  logic       m_out;
  int         m_cnt, m_div;
  logic [3:0] m_code;

  task automatic model_step(input logic i, k, d, input logic [3:0] c);
    logic tk;
    if (c != m_code) begin
      m_code = c; m_cnt = 0; m_div = 0;
    end else begin
      tk = 1'b0;
      if (c == 0) tk = d;
      else if (c < 4) tk = k;
      else if (d) begin
        tk = (m_div == dv[c] - 1);
        m_div = tk ? 0 : m_div + 1;
      end
      if (tk) begin
        if (c == 0) m_out = i;
        else if (i == m_out) m_cnt = 0;
        else if (m_cnt == nt[c] - 1) begin m_out = ~m_out; m_cnt = 0; end
        else m_cnt++;
      end
    end
  endtask

  task automatic drv(input logic i, k, d, input logic [3:0] c, input string tag, input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      sig_in = i; kern_ce = k; dts_ce = d; fcode = c;
      model_step(i, k, d, c);
      q.push_back('{m_out, tag});
    end
  endtask

  // monitor: compares each expected item just after the edge that produces it
  initial begin
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (sig_out !== e.v) begin
          errors++;
          $display("FAIL %s sig_out=%b expected=%b at %0t", e.tag, sig_out, e.v, $time);
        end
      end
    end
  end

  initial begin
    m_out = 1'b0; m_cnt = 0; m_div = 0; m_code = 4'd0;
    repeat (4) @(negedge clk);
    checks++;
    if (sig_out !== 1'b0) begin
      errors++; $display("FAIL R1 sig_out=%b expected=0", sig_out);
    end
    rst_n = 1'b1;
    // R2: bypass follows on dts_ce, ignores kern_ce
    drv(1, 0, 1, 0, "R2", 2);
    drv(0, 1, 0, 0, "R2", 3);
    drv(0, 0, 1, 0, "R2", 1);
    drv(1, 1, 0, 0, "R7", 3);
    // R3: kernel-rate codes, glitch one short then full run
    drv(1, 1, 0, 1, "R8", 1);
    drv(1, 1, 0, 1, "R3", 1);
    drv(0, 1, 0, 1, "R6", 2);
    drv(1, 1, 1, 1, "R3", 3);
    drv(0, 0, 1, 1, "R3", 4);
    drv(1, 1, 0, 3, "R3", 8);
    drv(0, 1, 0, 3, "R6", 2);
    drv(0, 1, 0, 3, "R3", 9);
    drv(1, 1, 0, 2, "R3", 6);
    // R8: change code mid-run, output holds and run restarts
    drv(0, 1, 0, 2, "R8", 3);
    drv(0, 1, 0, 1, "R8", 1);
    drv(0, 1, 0, 1, "R8", 3);
    // R4 / R9: dts-divided codes with steady input
    drv(1, 0, 1, 4, "R9", 14);
    drv(0, 0, 1, 7, "R9", 40);
    drv(1, 1, 0, 9, "R7", 20);
    drv(1, 0, 1, 9, "R4", 70);
    drv(0, 0, 1, 5, "R4", 20);
    // R5: slow codes, one short glitch then full run
    drv(1, 0, 1, 10, "R5", 16 * 4 + 1);
    drv(0, 0, 1, 10, "R6", 20);
    drv(1, 0, 1, 10, "R5", 100);
    drv(0, 0, 1, 15, "R5", 270);
    drv(1, 0, 1, 13, "R5", 170);
    // random stress over all codes
    begin
      logic [3:0] c = 4'd6;
      logic i = 1'b0;
      for (int j = 0; j < 20000; j++) begin
        if ($urandom_range(0, 499) == 0) c = 4'($urandom_range(0, 15));
        if ($urandom_range(0, 19) == 0) i = ~i;
        if ($urandom_range(0, 49) == 0) i = ~i;
        drv(i, 1'($urandom), 1'($urandom_range(0, 3) != 0), c, "R6", 1);
      end
    end
    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #600000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule